// File: doc/BRIEF.md
# Software-Pipelined Loop Branch Resolver

This block decides the direction of the closing branch of a software-pipelined loop and keeps the small amount of state that such a branch owns. That state is a 64-bit trip counter, a 6-bit drain-stage counter, and three rotating-base offsets for the general, floating-point and predicate register files. Each cycle it may receive one request. The request carries a two-bit branch kind and a guard predicate. In the same cycle the block answers with the branch direction, a rotate strobe, and the bit to be written into the highest rotating predicate. It updates its counters and bases on the following clock edge.

There are two loop families. A counted branch is steered by the trip counter while that counter is non-zero, and then by the drain counter. A conditional branch is steered by its guard predicate, and then by the drain counter. Each family comes in a bottom-tested form and a mid-loop form, and the two forms report the same continue/leave outcome with opposite taken polarity. Software initializes the two counters through dedicated load ports. The rotating bases step down by one on each rotation and wrap modulo the size of each file's rotating region.

Top module: `loop_branch_unit`

## Requirements
- R1: `req_kind` encodes 00 counted/bottom, 01 counted/mid, 10 conditional/bottom, 11 conditional/mid; bit 0 set means `br_taken` is high when the loop is left, bit 0 clear means `br_taken` is high when the loop continues; with `req_valid` high the outputs reflect the current counters combinationally.
- R2: Counted kind with trip counter non-zero: continue, trip counter minus one, drain counter unchanged, rotate, `pred_val` = 1.
- R3: Counted kind, trip counter zero, drain counter above one: continue, drain counter minus one, rotate, `pred_val` = 0.
- R4: Counted kind, trip counter zero, drain counter equal to one: leave, drain counter becomes zero, rotate, `pred_val` = 0.
- R5: Counted kind with both counters zero: leave, no counter or base change, `rot_strobe` low, `pred_we` high with `pred_val` = 0.
- R6: Conditional kind with guard 1: continue, rotate, `pred_val` = 0, drain counter unchanged.
- R7: Conditional kind, guard 0, drain counter above one: continue, drain counter minus one, rotate, `pred_val` = 0.
- R8: Conditional kind, guard 0, drain counter equal to one: leave, drain counter becomes zero, rotate, `pred_val` = 0.
- R9: Conditional kind, guard 0, drain counter zero: leave, no rotation, no counter change, `pred_we` high with `pred_val` = 0.
- R10: Counted kinds ignore `req_qp`; conditional kinds never change the trip counter and do not depend on it.
- R11: Each rotation decrements `gr_base`, `fr_base` and `pr_base` by one, and each base wraps from 0 to 95, 95 and 47 respectively.
- R12: A counter load takes effect on the next edge whether or not a request is valid, and it overrides that counter's branch update in the same cycle, while rotation still happens.
- R13: Synchronous reset clears both counters and all three bases; with `req_valid` low, `br_taken`, `rot_strobe` and `pred_we` are low and no state changes except loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A branch request is present this cycle |
| req_kind | input | 2 | Branch kind (see R1) |
| req_qp | input | 1 | Guard predicate of the request |
| lc_load | input | 1 | Load the trip counter |
| lc_load_val | input | 64 | Trip counter load value |
| ec_load | input | 1 | Load the drain counter |
| ec_load_val | input | 6 | Drain counter load value |
| br_taken | output | 1 | Branch direction |
| rot_strobe | output | 1 | Registers rotate on this request |
| pred_we | output | 1 | Top rotating predicate is written |
| pred_val | output | 1 | Value written into the top rotating predicate |
| lc_q | output | 64 | Trip counter |
| ec_q | output | 6 | Drain counter |
| gr_base | output | 7 | General register rotating base |
| fr_base | output | 7 | Floating-point register rotating base |
| pr_base | output | 6 | Predicate register rotating base |

## Verification
A directed counted loop walks the trip counter down to zero, then drains the stage counter through values above one and equal to one, and finally issues a branch with both counters at zero. This pass separates the four counted cases and shows the first rotation wrapping each base. A conditional sequence repeats the drain walk with the guard set and cleared while the trip counter holds a non-zero value, which shows that this counter is never touched. Further steps toggle the guard on counted branches, fire loads in the same cycle as branches, and assert reset mid-run. After that, a long random mix of kinds, guards and small counter values, with occasional loads, is compared against the bench model in every cycle.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

   typedef enum logic [1:0] {
      BR_CNT_BOT  = 2'b00,
      BR_CNT_MID  = 2'b01,
      BR_COND_BOT = 2'b10,
      BR_COND_MID = 2'b11
   } br_kind_e;

   typedef struct packed {
      logic cont;
      logic rotate;
      logic dec_lc;
      logic dec_ec;
      logic pred_val;
   } br_act_t;

endpackage

// File: rtl/lbr_decide.sv
module lbr_decide
   import lbr_pkg::*;
#(
   parameter int unsigned LC_W = 64,
   parameter int unsigned EC_W = 6
) (
   input  logic [1:0]      kind,
   input  logic            qp,
   input  logic [LC_W-1:0] lc,
   input  logic [EC_W-1:0] ec,
   output br_act_t         act
);
   logic counted;
   logic lc_nz;
   logic ec_nz;
   logic ec_gt1;

   assign counted = ~kind[1];
   assign lc_nz   = |lc;
   assign ec_nz   = |ec;
   assign ec_gt1  = ec > EC_W'(1);

   always_comb begin
      act = '0;
      if (counted && lc_nz) begin
         act.cont     = 1'b1;
         act.rotate   = 1'b1;
         act.dec_lc   = 1'b1;
         act.pred_val = 1'b1;
      end else if (!counted && qp) begin
         act.cont   = 1'b1;
         act.rotate = 1'b1;
      end else if (ec_nz) begin
         act.cont   = ec_gt1;
         act.rotate = 1'b1;
         act.dec_ec = 1'b1;
      end
   end

   // R2: only one counter may be decremented per branch
   always_comb begin
      if (act.dec_lc) assert_one_counter_R2 : assert (!act.dec_ec);
   end

   // R10: the trip counter is never consumed by a conditional kind
   always_comb begin
      if (kind[1]) assert_cond_no_lc_R10 : assert (!act.dec_lc && !act.pred_val);
   end
endmodule

// File: rtl/lbr_rot_base.sv
module lbr_rot_base #(
   parameter int unsigned SIZE = 96,
   parameter int unsigned W    = $clog2(SIZE)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step,
   output logic [W-1:0] base
);
   localparam logic [W-1:0] TOP = W'(SIZE - 1);
   logic [W-1:0] nxt;

   generate
      if (SIZE < 2) begin : g_bad_size
         $error("lbr_rot_base: SIZE must be at least 2");
      end
      if ((SIZE & (SIZE - 1)) == 0) begin : g_pow2
         assign nxt = base - 1'b1;
      end else begin : g_mod
         assign nxt = (base == '0) ? TOP : base - 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       base <= '0;
      else if (step) base <= nxt;
   end

   assert_wrap_R11 : assert property (@(posedge clk) disable iff (rst)
      step && base == '0 |=> base == TOP);
   assert_step_R11 : assert property (@(posedge clk) disable iff (rst)
      step && base != '0 |=> base == $past(base) - 1'b1);
   assert_hold_R11 : assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(base));
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
   import lbr_pkg::*;
#(
   parameter int unsigned LC_W   = 64,
   parameter int unsigned EC_W   = 6,
   parameter int unsigned GR_ROT = 96,
   parameter int unsigned FR_ROT = 96,
   parameter int unsigned PR_ROT = 48,
   parameter int unsigned GR_W   = $clog2(GR_ROT),
   parameter int unsigned FR_W   = $clog2(FR_ROT),
   parameter int unsigned PR_W   = $clog2(PR_ROT)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            req_valid,
   input  logic [1:0]      req_kind,
   input  logic            req_qp,
   input  logic            lc_load,
   input  logic [LC_W-1:0] lc_load_val,
   input  logic            ec_load,
   input  logic [EC_W-1:0] ec_load_val,
   output logic            br_taken,
   output logic            rot_strobe,
   output logic            pred_we,
   output logic            pred_val,
   output logic [LC_W-1:0] lc_q,
   output logic [EC_W-1:0] ec_q,
   output logic [GR_W-1:0] gr_base,
   output logic [FR_W-1:0] fr_base,
   output logic [PR_W-1:0] pr_base
);
   generate
      if (EC_W < 2) begin : g_bad_ec
         $error("loop_branch_unit: EC_W must be at least 2");
      end
      if (LC_W < 1) begin : g_bad_lc
         $error("loop_branch_unit: LC_W must be at least 1");
      end
   endgenerate

   br_act_t act;

   lbr_decide #(.LC_W(LC_W), .EC_W(EC_W)) u_decide (
      .kind (req_kind),
      .qp   (req_qp),
      .lc   (lc_q),
      .ec   (ec_q),
      .act  (act)
   );

   assign br_taken   = req_valid & (req_kind[0] ? ~act.cont : act.cont);
   assign rot_strobe = req_valid & act.rotate;
   assign pred_we    = req_valid;
   assign pred_val   = req_valid & act.pred_val;

   always_ff @(posedge clk) begin
      if (rst)                          lc_q <= '0;
      else if (lc_load)                 lc_q <= lc_load_val;
      else if (req_valid && act.dec_lc) lc_q <= lc_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)                          ec_q <= '0;
      else if (ec_load)                 ec_q <= ec_load_val;
      else if (req_valid && act.dec_ec) ec_q <= ec_q - 1'b1;
   end

   lbr_rot_base #(.SIZE(GR_ROT), .W(GR_W)) u_gr (
      .clk (clk), .rst (rst), .step (rot_strobe), .base (gr_base));
   lbr_rot_base #(.SIZE(FR_ROT), .W(FR_W)) u_fr (
      .clk (clk), .rst (rst), .step (rot_strobe), .base (fr_base));
   lbr_rot_base #(.SIZE(PR_ROT), .W(PR_W)) u_pr (
      .clk (clk), .rst (rst), .step (rot_strobe), .base (pr_base));

   assert_lc_load_R12 : assert property (@(posedge clk) disable iff (rst)
      lc_load |=> lc_q == $past(lc_load_val));
   assert_ec_load_R12 : assert property (@(posedge clk) disable iff (rst)
      ec_load |=> ec_q == $past(ec_load_val));
   assert_cond_keeps_lc_R10 : assert property (@(posedge clk) disable iff (rst)
      req_valid && req_kind[1] && !lc_load |=> $stable(lc_q));
   assert_idle_quiet_R13 : assert property (@(posedge clk) disable iff (rst)
      !req_valid |-> !br_taken && !rot_strobe && !pred_we);
   assert_idle_hold_R13 : assert property (@(posedge clk) disable iff (rst)
      !req_valid && !lc_load && !ec_load |=> $stable(lc_q) && $stable(ec_q));
   assert_empty_exit_R5 : assert property (@(posedge clk) disable iff (rst)
      req_valid && !req_kind[1] && lc_q == '0 && ec_q == '0 && !lc_load && !ec_load
      |-> !rot_strobe && !pred_val ##1 $stable(lc_q) && $stable(ec_q));
   assert_mid_kernel_R1 : assert property (@(posedge clk) disable iff (rst)
      req_valid && req_kind[0] && !req_kind[1] && lc_q != '0 |-> !br_taken);
   assert_drained_cond_R9 : assert property (@(posedge clk) disable iff (rst)
      req_valid && req_kind[1] && !req_qp && ec_q == '0 |-> !rot_strobe);
   assert_last_stage_R4 : assert property (@(posedge clk) disable iff (rst)
      req_valid && !req_kind[1] && lc_q == '0 && ec_q == EC_W'(1) && !ec_load
      |=> ec_q == '0);
endmodule

// File: tb/loop_branch_unit_test.sv
module loop_branch_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic        req_valid;
   logic [1:0]  req_kind;
   logic        req_qp;
   logic        lc_load;
   logic [63:0] lc_load_val;
   logic        ec_load;
   logic [5:0]  ec_load_val;
   logic        br_taken, rot_strobe, pred_we, pred_val;
   logic [63:0] lc_q;
   logic [5:0]  ec_q;
   logic [6:0]  gr_base, fr_base;
   logic [5:0]  pr_base;

   loop_branch_unit uut (
      .clk (clk), .rst (rst), .req_valid (req_valid), .req_kind (req_kind),
      .req_qp (req_qp), .lc_load (lc_load), .lc_load_val (lc_load_val),
      .ec_load (ec_load), .ec_load_val (ec_load_val), .br_taken (br_taken),
      .rot_strobe (rot_strobe), .pred_we (pred_we), .pred_val (pred_val),
      .lc_q (lc_q), .ec_q (ec_q), .gr_base (gr_base), .fr_base (fr_base),
      .pr_base (pr_base));

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [63:0] m_lc;
   logic [5:0]  m_ec;
   int          m_gr, m_fr, m_pr;

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic string case_tag(logic [1:0] k, logic qp, logic [63:0] lc, logic [5:0] ec);
      if (!k[1]) begin
         if (lc != 0) return "R2";
         if (ec > 1)  return "R3";
         if (ec == 1) return "R4";
         return "R5";
      end
      if (qp)      return "R6";
      if (ec > 1)  return "R7";
      if (ec == 1) return "R8";
      return "R9";
   endfunction

   // expected behaviour: {cont, rotate, dec_lc, dec_ec, pred}
   function automatic logic [4:0] expect_act(logic [1:0] k, logic qp, logic [63:0] lc, logic [5:0] ec);
      if (!k[1] && lc != 0) return 5'b11101;
      if (k[1] && qp)       return 5'b11000;
      if (ec > 1)           return 5'b11010;
      if (ec == 1)          return 5'b01010;
      return 5'b00000;
   endfunction

   task automatic check_state(input string tag);
      chk(tag, "lc_q", lc_q, m_lc);
      chk(tag, "ec_q", {58'd0, ec_q}, {58'd0, m_ec});
      chk("R11", "gr_base", 64'(gr_base), 64'(m_gr));
      chk("R11", "fr_base", 64'(fr_base), 64'(m_fr));
      chk("R11", "pr_base", 64'(pr_base), 64'(m_pr));
   endtask

   task automatic step(input logic v, input logic [1:0] k, input logic qp,
                       input logic ll, input logic [63:0] lv,
                       input logic el, input logic [5:0] ev);
      logic [4:0] e;
      string tag;
      @(negedge clk);
      req_valid = v; req_kind = k; req_qp = qp;
      lc_load = ll; lc_load_val = lv; ec_load = el; ec_load_val = ev;
      #1;
      e   = expect_act(k, qp, m_lc, m_ec);
      tag = case_tag(k, qp, m_lc, m_ec);
      if (v) begin
         chk("R1", "br_taken", 64'(br_taken), 64'(k[0] ? !e[4] : e[4]));
         chk(tag, "rot_strobe", 64'(rot_strobe), 64'(e[3]));
         chk(tag, "pred_we", 64'(pred_we), 64'd1);
         chk(tag, "pred_val", 64'(pred_val), 64'(e[0]));
      end else begin
         chk("R13", "idle outputs", {61'd0, br_taken, rot_strobe, pred_we}, 64'd0);
      end
      @(posedge clk);
      if (v && e[2]) m_lc = m_lc - 1;
      if (v && e[1]) m_ec = m_ec - 1;
      if (v && e[3]) begin
         m_gr = (m_gr == 0) ? 95 : m_gr - 1;
         m_fr = (m_fr == 0) ? 95 : m_fr - 1;
         m_pr = (m_pr == 0) ? 47 : m_pr - 1;
      end
      if (ll) m_lc = lv;
      if (el) m_ec = ev;
      #1;
      check_state((ll || el) ? "R12" : (v ? tag : "R13"));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; req_valid = 1'b0; lc_load = 1'b0; ec_load = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_lc = '0; m_ec = '0; m_gr = 0; m_fr = 0; m_pr = 0;
      #1;
      check_state("R13");
   endtask

   initial begin
      rst = 1'b1; req_valid = 1'b0; req_kind = 2'b00; req_qp = 1'b0;
      lc_load = 1'b0; lc_load_val = '0; ec_load = 1'b0; ec_load_val = '0;
      void'($urandom(32'd4242));
      do_reset();

      // R12: loads without a request; lc=2, ec=3
      step(1'b0, 2'b00, 1'b0, 1'b1, 64'd2, 1'b1, 6'd3);
      // counted bottom: R2 (x2, first rotation wraps bases, R11), R3 (x2), R4, R5
      // guard toggled on counted branches: R10
      step(1'b1, 2'b00, 1'b0, 1'b0, 64'd0, 1'b0, 6'd0);
      step(1'b1, 2'b00, 1'b1, 1'b0, 64'd0, 1'b0, 6'd0);
      step(1'b1, 2'b00, 1'b1, 1'b0, 64'd0, 1'b0, 6'd0);
      step(1'b1, 2'b01, 1'b0, 1'b0, 64'd0, 1'b0, 6'd0);
      step(1'b1, 2'b00, 1'b1, 1'b0, 64'd0, 1'b0, 6'd0);
      step(1'b1, 2'b01, 1'b1, 1'b0, 64'd0, 1'b0, 6'd0);
      step(1'b1, 2'b00, 1'b0, 1'b0, 64'd0, 1'b0, 6'd0);

      // R12: load in the same cycle as a draining branch; ec=2 first
      step(1'b0, 2'b00, 1'b0, 1'b0, 64'd0, 1'b1, 6'd2);
      step(1'b1, 2'b01, 1'b0, 1'b1, 64'd9, 1'b0, 6'd0);
      step(1'b1, 2'b00, 1'b0, 1'b0, 64'd0, 1'b1, 6'd5);

      // conditional kinds with lc=7 held (R10): R6, R7, R8, R9
      step(1'b0, 2'b00, 1'b0, 1'b1, 64'd7, 1'b1, 6'd2);
      step(1'b1, 2'b11, 1'b1, 1'b0, 64'd0, 1'b0, 6'd0);
      step(1'b1, 2'b10, 1'b1, 1'b0, 64'd0, 1'b0, 6'd0);
      step(1'b1, 2'b10, 1'b0, 1'b0, 64'd0, 1'b0, 6'd0);
      step(1'b1, 2'b11, 1'b0, 1'b0, 64'd0, 1'b0, 6'd0);
      step(1'b1, 2'b10, 1'b0, 1'b0, 64'd0, 1'b0, 6'd0);
      step(1'b1, 2'b11, 1'b0, 1'b0, 64'd0, 1'b0, 6'd0);

      // wide trip counter: R2
      step(1'b0, 2'b00, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 6'd0);
      step(1'b1, 2'b01, 1'b0, 1'b0, 64'd0, 1'b0, 6'd0);

      // R13: reset in mid-run clears everything
      do_reset();

      for (int i = 0; i < 3000; i++) begin
         logic       ll, el;
         logic [1:0] k;
         ll = ($urandom_range(9, 0) == 0);
         el = ($urandom_range(7, 0) == 0);
         k  = 2'($urandom_range(3, 0));
         step(($urandom_range(5, 0) != 0), k, 1'($urandom_range(1, 0)),
              ll, 64'($urandom_range(4, 0)), el, 6'($urandom_range(4, 0)));
      end

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule